// File: doc/BRIEF.md
# Serial Digital Potentiometer Write Controller

This block is the write side of a dual digital potentiometer, controlled over a two-wire serial bus. It sees the bus clock and data lines as plain inputs and answers through a single pull-low output, so it sits behind an open-drain pad. The block oversamples both lines with the system clock and finds start and stop conditions. It receives a three-byte command: a fixed device address, an instruction byte and a data byte.

The instruction byte picks one of two wiper channels and chooses a volatile or a nonvolatile write. Channel 0 has 100 taps and channel 1 has 256 taps. The data byte is clamped to the top tap of the chosen channel and written into that channel's wiper counter register. A nonvolatile write also updates a shadow register, which stands in for nonvolatile storage. A write only lands while the write-enable latch input is high. The power-up reset reloads every wiper from its shadow. A separate storage-initialise input loads the shadows with their initial contents, which models a fresh part.

Top module: `potw_top`

## Requirements
- R1: While `rst_n` is low, `sda_pull_o` is low on the following clock and each wiper loads its shadow value. After `nv_init_n` has been low, the shadows hold `NV_INIT`: tap 0 on channel 0 and tap 128 on channel 1.
- R2: The address byte is sent MSB first. Only the value 0xAE is acknowledged, which means `sda_pull_o` is high during the ninth SCL high phase. Any other address gets no acknowledge and writes nothing. `sda_pull_o` changes only while SCL is low.
- R3: Instruction byte layout: bit 7 is the write type (0 volatile, 1 nonvolatile), bits 6..2 must be zero, and bits 1..0 are the channel code (00 selects the 100-tap channel 0, 01 selects the 256-tap channel 1). A valid instruction byte and the data byte that follows it are both acknowledged.
- R4: An instruction byte with any of bits 6..2 set, or with channel code 10 or 11, is not acknowledged. The rest of the command then writes nothing.
- R5: On the 256-tap channel the wiper equals the data byte, 0x00 to 0xFF.
- R6: On the 100-tap channel a data value of 0 to 99 is taken as is. Any larger value sets the wiper to 99, and it never wraps.
- R7: The new wiper value is visible during the SCL high phase that samples data bit D0, before the acknowledge clock.
- R8: After a power-up reset each wiper shows the value of its last nonvolatile write. A later volatile write does not survive the reset.
- R9: With `wel_i` low, neither a volatile nor a nonvolatile write changes a wiper or a shadow.
- R10: A start condition in the middle of a command drops that command without writing. Address reception begins again.
- R11: A stop condition returns the block to idle without writing. Bus clocks that follow without a new start are not acknowledged and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Power-up reset, active low; reloads wipers from shadows |
| nv_init_n | input | 1 | Storage initialise, active low; loads shadows with NV_INIT |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| wel_i | input | 1 | Write-enable latch; writes apply only while high |
| sda_pull_o | output | 1 | Drives the data pad low (acknowledge) when high |
| wiper_c100_o | output | 8 | Wiper position of the 100-tap channel |
| wiper_c256_o | output | 8 | Wiper position of the 256-tap channel |

## Verification
The hardest cases to reach from the ports are an abort between bits and the exact commit instant. For an abort, the bench leaves a data byte half sent and then issues a repeated start, or it stops after the instruction byte and clocks stray bits with no start. For the commit instant, the bench samples the wiper outputs inside the SCL high phase of bit D0. The difference between volatile and nonvolatile writes only shows after a power-up reset pulse. So the bench mixes both write types on both channels, then pulses reset and compares the wipers with the last nonvolatile values.

// File: rtl/potw_pkg.sv
package potw_pkg;
    localparam int unsigned NUM_CH  = 2;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CNT_W   = $clog2(BYTE_W) + 1;
    localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned CH_TAPS [NUM_CH] = '{100, 256};

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_ACK, ST_HOLD
    } rx_state_e;

    typedef struct packed {
        rx_state_e           state;
        rx_state_e           after;
        logic [BYTE_W-1:0]   shreg;
        logic [CNT_W-1:0]    cnt;
        logic                ack_pend;
        logic                pull;
        logic                wt;
        logic [CH_W-1:0]     ch;
        logic                wr_vld;
        logic                wr_nv;
        logic [CH_W-1:0]     wr_ch;
        logic [BYTE_W-1:0]   wr_val;
    } rx_regs_t;
endpackage

// File: rtl/potw_sync.sv
module potw_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        IDLE_LV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], din};
        if (!rst_n) pipe_d = {(STAGES+1){IDLE_LV}};
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    assign level = pipe_q[STAGES-1];
    assign rise  =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall  = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/potw_rx.sv
module potw_rx
    import potw_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hAE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lv,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lv,
    input  logic              sda_rise,
    input  logic              sda_fall,
    output logic              pull,
    output logic              wr_vld,
    output logic              wr_nv,
    output logic [CH_W-1:0]   wr_ch,
    output logic [BYTE_W-1:0] wr_val
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    rx_regs_t r_d, r_q;
    logic [BYTE_W-1:0] nxt_byte;
    logic start_c, stop_c, receiving;

    assign start_c   = scl_lv & sda_fall;
    assign stop_c    = scl_lv & sda_rise;
    assign nxt_byte  = {r_q.shreg[BYTE_W-2:0], sda_lv};
    assign receiving = (r_q.state == ST_ADDR) || (r_q.state == ST_INSTR) ||
                       (r_q.state == ST_DATA);

    always_comb begin
        r_d        = r_q;
        r_d.wr_vld = 1'b0;
        if (start_c) begin
            r_d.state    = ST_ADDR;
            r_d.cnt      = '0;
            r_d.ack_pend = 1'b0;
            r_d.pull     = 1'b0;
        end else if (stop_c) begin
            r_d.state    = ST_IDLE;
            r_d.ack_pend = 1'b0;
            r_d.pull     = 1'b0;
        end else if (scl_rise && receiving && r_q.cnt < FULL) begin
            r_d.shreg = nxt_byte;
            r_d.cnt   = r_q.cnt + 1'b1;
            if (r_q.cnt == LAST_BIT) begin
                unique case (r_q.state)
                    ST_ADDR: begin
                        if (nxt_byte == DEV_ADDR) begin
                            r_d.ack_pend = 1'b1;
                            r_d.after    = ST_INSTR;
                        end else begin
                            r_d.state = ST_HOLD;
                        end
                    end
                    ST_INSTR: begin
                        if (nxt_byte[6:2] == 5'b0 &&
                            32'(nxt_byte[1:0]) < NUM_CH) begin
                            r_d.wt       = nxt_byte[BYTE_W-1];
                            r_d.ch       = nxt_byte[CH_W-1:0];
                            r_d.ack_pend = 1'b1;
                            r_d.after    = ST_DATA;
                        end else begin
                            r_d.state = ST_HOLD;
                        end
                    end
                    default: begin
                        r_d.wr_vld   = 1'b1;
                        r_d.wr_nv    = r_q.wt;
                        r_d.wr_ch    = r_q.ch;
                        r_d.wr_val   = nxt_byte;
                        r_d.ack_pend = 1'b1;
                        r_d.after    = ST_HOLD;
                    end
                endcase
            end
        end else if (scl_fall) begin
            if (r_q.state == ST_ACK) begin
                r_d.pull  = 1'b0;
                r_d.state = r_q.after;
                r_d.cnt   = '0;
            end else if (r_q.ack_pend) begin
                r_d.pull     = 1'b1;
                r_d.ack_pend = 1'b0;
                r_d.state    = ST_ACK;
            end
        end
        if (!rst_n) begin
            r_d       = '0;
            r_d.state = ST_IDLE;
            r_d.after = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign pull   = r_q.pull;
    assign wr_vld = r_q.wr_vld;
    assign wr_nv  = r_q.wr_nv;
    assign wr_ch  = r_q.wr_ch;
    assign wr_val = r_q.wr_val;
endmodule

// File: rtl/potw_bank.sv
module potw_bank
    import potw_pkg::*;
#(
    parameter logic [NUM_CH*BYTE_W-1:0] NV_INIT = {8'd128, 8'd0}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     nv_init_n,
    input  logic                     wel,
    input  logic                     wr_vld,
    input  logic                     wr_nv,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [BYTE_W-1:0]        wr_val,
    output logic [NUM_CH*BYTE_W-1:0] wipers
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [BYTE_W-1:0] TOP_TAP = BYTE_W'(CH_TAPS[g] - 1);
        logic [BYTE_W-1:0] wcr_d, wcr_q, nv_d, nv_q, clamped;
        logic hit;

        assign hit     = wr_vld & wel & (32'(wr_ch) == g);
        assign clamped = (wr_val > TOP_TAP) ? TOP_TAP : wr_val;

        always_comb begin
            wcr_d = wcr_q;
            nv_d  = nv_q;
            if (hit) begin
                wcr_d = clamped;
                if (wr_nv) nv_d = clamped;
            end
            if (!nv_init_n) nv_d  = NV_INIT[g*BYTE_W +: BYTE_W];
            if (!rst_n)     wcr_d = nv_q;
        end

        always_ff @(posedge clk) begin
            wcr_q <= wcr_d;
            nv_q  <= nv_d;
        end

        assign wipers[g*BYTE_W +: BYTE_W] = wcr_q;
    end
endmodule

// File: rtl/potw_top.sv
module potw_top
    import potw_pkg::*;
#(
    parameter logic [BYTE_W-1:0]        DEV_ADDR    = 8'hAE,
    parameter int unsigned              SYNC_STAGES = 2,
    parameter logic [NUM_CH*BYTE_W-1:0] NV_INIT     = {8'd128, 8'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_init_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wel_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] wiper_c100_o,
    output logic [BYTE_W-1:0] wiper_c256_o
);
    logic [1:0] pad_in, lv, rise, fall;
    logic wr_vld, wr_nv;
    logic [CH_W-1:0] wr_ch;
    logic [BYTE_W-1:0] wr_val;
    logic [NUM_CH*BYTE_W-1:0] wipers;

    assign pad_in = {sda_i, scl_i};

    for (genvar l = 0; l < 2; l++) begin : g_line
        potw_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(pad_in[l]),
            .level(lv[l]), .rise(rise[l]), .fall(fall[l])
        );
    end

    potw_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .scl_lv(lv[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
        .sda_lv(lv[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
        .pull(sda_pull_o), .wr_vld(wr_vld), .wr_nv(wr_nv),
        .wr_ch(wr_ch), .wr_val(wr_val)
    );

    potw_bank #(.NV_INIT(NV_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .wel(wel_i),
        .wr_vld(wr_vld), .wr_nv(wr_nv), .wr_ch(wr_ch), .wr_val(wr_val),
        .wipers(wipers)
    );

    assign wiper_c100_o = wipers[BYTE_W-1:0];
    assign wiper_c256_o = wipers[2*BYTE_W-1:BYTE_W];
endmodule

// File: rtl/potw_chk.sv
module potw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       wel_i,
    input logic       sda_pull_o,
    input logic [7:0] wiper_c100_o,
    input logic [7:0] wiper_c256_o
);
    AST_RESET_RELEASES_PULL: assert property (@(posedge clk)
        !rst_n |=> !sda_pull_o);                                      // R1
    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_i);                // R2
    AST_C100_NEVER_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        wiper_c100_o <= 8'd99);                                       // R6
    AST_NO_WEL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_i |=> ($stable(wiper_c100_o) && $stable(wiper_c256_o))); // R9
endmodule

bind potw_top potw_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wel_i(wel_i),
    .sda_pull_o(sda_pull_o), .wiper_c100_o(wiper_c100_o),
    .wiper_c256_o(wiper_c256_o)
);

// File: tb/potw_top_tb.sv
module potw_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0, nv_init_n = 1'b0, wel = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic pull;
    logic [7:0] w100, w256;
    wire sda_line = sda_m & ~pull;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    potw_top u_dut (
        .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .scl_i(scl_m),
        .sda_i(sda_line), .wel_i(wel), .sda_pull_o(pull),
        .wiper_c100_o(w100), .wiper_c256_o(w256)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic bus_bit(input logic b);
        sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    endtask

    task automatic ack_clk(output logic a);
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); a = pull; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic a, output logic [15:0] at8);
        at8 = '0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1'b1; q();
            if (i == 0) at8 = {w256, w100};
            q(); scl_m = 1'b0; q();
        end
        ack_clk(a);
    endtask

    task automatic cmd(input logic [7:0] ad, input logic [7:0] ins, input logic [7:0] dat,
                       output logic [2:0] acks, output logic [15:0] at8);
        logic a;
        logic [15:0] tmp;
        bus_start();
        bus_byte(ad, a, tmp);   acks[2] = a;
        bus_byte(ins, a, tmp);  acks[1] = a;
        bus_byte(dat, a, at8);  acks[0] = a;
        bus_stop();
    endtask

    task automatic power_cycle();
        rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        nv_init_n = 1'b0; rst_n = 1'b0;
        repeat (6) @(negedge clk);
        nv_init_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pull low in reset", pull, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 c100 init", w100, 0);
        chk("R1 c256 init", w256, 128);
    endtask

    task automatic t_write256();
        logic [2:0] ak; logic [15:0] at8;
        cmd(8'hAE, 8'h01, 8'h3C, ak, at8);
        chk("R2 R3 acks on valid write", ak, 3'b111);
        chk("R5 c256 = 0x3C", w256, 8'h3C);
        cmd(8'hAE, 8'h01, 8'hFF, ak, at8);
        chk("R5 c256 = 0xFF", w256, 8'hFF);
        cmd(8'hAE, 8'h01, 8'h00, ak, at8);
        chk("R5 c256 = 0x00", w256, 0);
    endtask

    task automatic t_clamp100();
        logic [2:0] ak; logic [15:0] at8;
        cmd(8'hAE, 8'h00, 8'd99, ak, at8);
        chk("R3 c100 acks", ak, 3'b111);
        chk("R6 c100 = 99", w100, 99);
        cmd(8'hAE, 8'h00, 8'd42, ak, at8);
        chk("R6 c100 = 42", w100, 42);
        cmd(8'hAE, 8'h00, 8'd100, ak, at8);
        chk("R6 c100 100 clamps", w100, 99);
        cmd(8'hAE, 8'h00, 8'hFF, ak, at8);
        chk("R6 c100 255 clamps", w100, 99);
        chk("R6 c256 untouched", w256, 0);
    endtask

    task automatic t_commit_time();
        logic [2:0] ak; logic [15:0] at8;
        cmd(8'hAE, 8'h01, 8'h5A, ak, at8);
        chk("R7 c256 during D0 high", at8[15:8], 8'h5A);
        cmd(8'hAE, 8'h00, 8'd17, ak, at8);
        chk("R7 c100 during D0 high", at8[7:0], 17);
    endtask

    task automatic t_volatile();
        logic [2:0] ak; logic [15:0] at8;
        cmd(8'hAE, 8'h81, 8'h77, ak, at8);
        chk("R8 nonvolatile write acks", ak, 3'b111);
        cmd(8'hAE, 8'h01, 8'h10, ak, at8);
        cmd(8'hAE, 8'h80, 8'd20, ak, at8);
        cmd(8'hAE, 8'h00, 8'd5, ak, at8);
        chk("R8 volatile c256 applied", w256, 8'h10);
        chk("R8 volatile c100 applied", w100, 5);
        power_cycle();
        chk("R8 c256 reverts to nv", w256, 8'h77);
        chk("R8 c100 reverts to nv", w100, 20);
    endtask

    task automatic t_wel();
        logic [2:0] ak; logic [15:0] at8;
        wel = 1'b0;
        cmd(8'hAE, 8'h81, 8'h99, ak, at8);
        cmd(8'hAE, 8'h00, 8'd33, ak, at8);
        chk("R9 c256 unchanged wel low", w256, 8'h77);
        chk("R9 c100 unchanged wel low", w100, 20);
        power_cycle();
        chk("R9 shadow unchanged wel low", w256, 8'h77);
        wel = 1'b1;
    endtask

    task automatic t_bad_addr();
        logic [2:0] ak; logic [15:0] at8;
        cmd(8'hAC, 8'h01, 8'h44, ak, at8);
        chk("R2 wrong address no ack", ak, 3'b000);
        chk("R2 wrong address no write", w256, 8'h77);
        cmd(8'h2E, 8'h01, 8'h44, ak, at8);
        chk("R2 wrong MSB no ack", ak[2], 0);
    endtask

    task automatic t_bad_instr();
        logic [2:0] ak; logic [15:0] at8;
        cmd(8'hAE, 8'h05, 8'h33, ak, at8);
        chk("R4 bit2 set nack", ak, 3'b100);
        cmd(8'hAE, 8'h41, 8'h33, ak, at8);
        chk("R4 bit6 set nack", ak[1], 0);
        cmd(8'hAE, 8'h02, 8'h33, ak, at8);
        chk("R4 code 10 nack", ak[1], 0);
        cmd(8'hAE, 8'h83, 8'h33, ak, at8);
        chk("R4 code 11 nack", ak[1], 0);
        chk("R4 c256 unchanged", w256, 8'h77);
        chk("R4 c100 unchanged", w100, 20);
    endtask

    task automatic t_restart();
        logic a; logic [15:0] at8;
        bus_start();
        bus_byte(8'hAE, a, at8);
        bus_byte(8'h01, a, at8);
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        bus_start();
        chk("R10 aborted command wrote nothing", w256, 8'h77);
        bus_byte(8'hAE, a, at8);
        chk("R10 address acked after restart", a, 1);
        bus_byte(8'h01, a, at8);
        bus_byte(8'h21, a, at8);
        bus_stop();
        chk("R10 write after restart", w256, 8'h21);
    endtask

    task automatic t_stop_abort();
        logic a; logic [15:0] at8;
        bus_start();
        bus_byte(8'hAE, a, at8);
        bus_byte(8'h01, a, at8);
        bus_stop();
        scl_m = 1'b0; q();
        bus_byte(8'h55, a, at8);
        chk("R11 no ack without start", a, 0);
        bus_stop();
        chk("R11 no write after stop", w256, 8'h21);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write256();
        t_clamp100();
        t_commit_time();
        t_volatile();
        t_wel();
        t_bad_addr();
        t_bad_instr();
        t_restart();
        t_stop_abort();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule